// File: doc/BRIEF.md
# Write Leveling Feedback Responder

This block is the memory-device side of write leveling. While the leveling-enable bit of the mode register is set, every rising edge of the data strobe takes a snapshot of the incoming clock level. The block then returns that snapshot on the data lines after a fixed latency, so the controller can tell on which side of the clock edge its strobe landed. No read strobe is produced with this feedback.

All inputs are already synchronous to a fast internal clock. The strobe edge arrives as a one-cycle event and the clock level arrives as a sampled bit. A static configuration input selects the feedback style. In the all-bit style every data bit carries the snapshot, and each bit settles at its own delay inside a bounded skew window. In the single-bit style only bit 0 carries the snapshot and the other bits are held low. A separate output-disable bit keeps the data lines undriven, so that a rank that is not being leveled stays silent while its internal state keeps running.

Top module: `wl_fb_responder`

## Requirements
- R1: After a synchronous active-low reset, with `lvl_en` low, `dq_oe` is 0 and `dq_out` is all zeros.
- R2: `dq_oe` is 1 exactly when `lvl_en` is 1 and `out_off` is 0, in the same cycle. Whenever `dq_oe` is 0, `dq_out` reads all zeros.
- R3: A `strobe_rise` pulse takes the value of `ck_level` only when it is sampled while `lvl_en` is 1. A pulse sampled while `lvl_en` is 0 has no effect, and after leveling is entered the outputs stay at zero.
- R4: With `prime_only` = 0, bit i of `dq_out` shows the captured level exactly WLO_CYC + i*SKEW_STEP clock edges after the edge that sampled the accepted strobe. Before that edge it keeps its previous value.
- R5: With `prime_only` = 1, bit 0 carries the feedback with latency WLO_CYC and bits 7..1 of `dq_out` stay 0 for the whole procedure.
- R6: A strobe accepted before a bit's pending update is due replaces that update, and the bit shows the newer level at the newer strobe's latency. A strobe that arrives on the very edge where an update is due does not cancel that update.
- R7: While `out_off` is 1, capture and per-bit timing keep running. When `out_off` returns to 0, `dq_out` shows the feedback gathered meanwhile, in that same cycle.
- R8: While `lvl_en` is 0 all feedback state is cleared, so on re-entry `dq_out` reads all zeros until a new strobe matures.
- R9: In all-bit mode, once the largest latency has passed since the last accepted strobe, all bits of `dq_out` are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lvl_en | input | 1 | Leveling mode enable from the mode register |
| out_off | input | 1 | Output disable; keeps the data lines undriven |
| prime_only | input | 1 | 1: feedback on bit 0 only; 0: feedback on all bits |
| ck_level | input | 1 | Sampled level of the external clock |
| strobe_rise | input | 1 | One-cycle event marking a rising strobe edge |
| dq_out | output | DQ_W (8) | Feedback data value |
| dq_oe | output | 1 | Output enable for the data lines |

## Verification
With the defaults (WLO_CYC = 4, SKEW_STEP = 1), a strobe is sampled at edge E and bit i must flip at edge E+4+i. So bit 0 is due 4 edges after the strobe and bit 7 is due 11 edges after it. Enable and disable effects (R2, R7) are combinational and due in the same cycle. Clearing (R8) is due one edge after `lvl_en` falls. Each time the bench drives a strobe burst, it computes the full expected data word for every cycle of the burst window. That covers overlapping strobes and the rule for strobes that land on the same edge as a due update. Each word is queued with its due cycle number, and a monitor compares the outputs at the falling edge of exactly that cycle. A bit that changes one cycle early or late therefore shows up as a mismatch.

// File: rtl/wl_fb_pkg.sv
// Package wl_fb_pkg
// Shared types and helper functions for the write leveling feedback
// responder. Assumes latencies are counted in fast-clock edges.
package wl_fb_pkg;

    // Feedback style selected by the static configuration input.
    typedef enum logic {
        FB_ALL   = 1'b0,
        FB_PRIME = 1'b1
    } fb_mode_e;

    // Index of the data bit that carries feedback in single-bit mode.
    localparam int PRIME_BIT = 0;

    // Per-bit latency: base latency plus a fixed skew step per bit index.
    function automatic int lane_delay(input int lane, input int base_cyc, input int step);
        return base_cyc + lane * step;
    endfunction

endpackage

// File: rtl/wl_fb_capture.sv
// Module wl_fb_capture
// Holds the clock level taken at the latest accepted strobe edge.
// Assumes strobe_rise is a one-cycle pulse synchronous to clk. Strobes
// are accepted only while leveling is enabled. The held level is
// cleared while leveling is off.
module wl_fb_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_en,
    input  logic strobe_rise,
    input  logic ck_level,
    output logic accept,
    output logic cap_level
);

    // Qualify the strobe with the leveling enable.
    always_comb begin
        accept = lvl_en && strobe_rise;
    end

    // Store the clock level on an accepted strobe; clear when leveling is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !lvl_en) begin
            cap_level <= 1'b0;
        end else if (accept) begin
            cap_level <= ck_level;
        end
    end

endmodule

// File: rtl/wl_fb_lane.sv
// Module wl_fb_lane
// One data bit of feedback. An accepted strobe loads a down counter
// with DELAY. The bit takes the captured level on the edge where the
// counter expires. A new strobe reloads the counter, which replaces a
// pending update. Assumes DELAY >= 1 and that CNT_W can hold DELAY.
// The lane clears when lane_en is low.
module wl_fb_lane #(
    parameter int DELAY = 4,
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lane_en,
    input  logic load,
    input  logic cap_level,
    output logic lane_q
);

    localparam logic [CNT_W-1:0] DLY  = CNT_W'(DELAY);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt_q;
    logic             due;

    // The pending update matures on this edge.
    always_comb begin
        due = (cnt_q == ONE);
    end

    // Latency counter: reload on a strobe, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !lane_en) begin
            cnt_q <= ZERO;
        end else if (load) begin
            cnt_q <= DLY;
        end else if (cnt_q != ZERO) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // Feedback bit: take the captured level when the counter expires.
    always_ff @(posedge clk) begin
        if (!rst_n || !lane_en) begin
            lane_q <= 1'b0;
        end else if (due) begin
            lane_q <= cap_level;
        end
    end

endmodule

// File: rtl/wl_fb_drive.sv
// Module wl_fb_drive
// Output stage. It enables the data lines only in leveling mode with
// outputs not disabled, and forces the value to zero when they are not
// enabled. Purely combinational; the pad driver itself is outside.
module wl_fb_drive #(
    parameter int DQ_W = 8
) (
    input  logic            lvl_en,
    input  logic            out_off,
    input  logic [DQ_W-1:0] lane_vec,
    output logic [DQ_W-1:0] dq_out,
    output logic            dq_oe
);

    // Enable and mask the feedback word.
    always_comb begin
        dq_oe  = lvl_en && !out_off;
        dq_out = dq_oe ? lane_vec : '0;
    end

endmodule

// File: rtl/wl_fb_responder.sv
// Module wl_fb_responder
// Write leveling feedback responder, device side. It samples ck_level
// on each strobe_rise while lvl_en is high. Each data bit returns the
// sample after its own latency WLO_CYC + i*SKEW_STEP. In single-bit
// mode only bit 0 reports and the other bits stay low. Assumes
// WLO_CYC >= 1, SKEW_STEP >= 0, and that prime_only changes only while
// lvl_en is low.
module wl_fb_responder
    import wl_fb_pkg::*;
#(
    parameter int DQ_W      = 8,
    parameter int WLO_CYC   = 4,
    parameter int SKEW_STEP = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lvl_en,
    input  logic            out_off,
    input  logic            prime_only,
    input  logic            ck_level,
    input  logic            strobe_rise,
    output logic [DQ_W-1:0] dq_out,
    output logic            dq_oe
);

    localparam int MAX_DLY = lane_delay(DQ_W - 1, WLO_CYC, SKEW_STEP);
    localparam int CNT_W   = $clog2(MAX_DLY + 1);

    fb_mode_e        mode;
    logic            accept;
    logic            cap_level;
    logic [DQ_W-1:0] lane_en;
    logic [DQ_W-1:0] lane_vec;

    // Decode the static feedback style.
    always_comb begin
        mode = fb_mode_e'(prime_only);
    end

    wl_fb_capture u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_en     (lvl_en),
        .strobe_rise(strobe_rise),
        .ck_level   (ck_level),
        .accept     (accept),
        .cap_level  (cap_level)
    );

    for (genvar i = 0; i < DQ_W; i++) begin : g_lane
        localparam bit IS_PRIME = (i == PRIME_BIT);

        // A lane runs in leveling mode; non-prime lanes stop in single-bit mode.
        if (IS_PRIME) begin : g_prime
            always_comb begin
                lane_en[i] = lvl_en;
            end
        end else begin : g_other
            always_comb begin
                lane_en[i] = lvl_en && (mode == FB_ALL);
            end
        end

        wl_fb_lane #(
            .DELAY(lane_delay(i, WLO_CYC, SKEW_STEP)),
            .CNT_W(CNT_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .lane_en  (lane_en[i]),
            .load     (accept),
            .cap_level(cap_level),
            .lane_q   (lane_vec[i])
        );
    end

    wl_fb_drive #(
        .DQ_W(DQ_W)
    ) u_drive (
        .lvl_en  (lvl_en),
        .out_off (out_off),
        .lane_vec(lane_vec),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe)
    );

endmodule

// File: rtl/wl_fb_responder_chk.sv
// Module wl_fb_responder_chk
// Assertion checker for wl_fb_responder, attached by bind. It keeps its
// own count of edges since the last accepted strobe, so that latency
// windows are checked without deep $past.
module wl_fb_responder_chk #(
    parameter int DQ_W      = 8,
    parameter int WLO_CYC   = 4,
    parameter int SKEW_STEP = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lvl_en,
    input logic            out_off,
    input logic            prime_only,
    input logic            strobe_rise,
    input logic [DQ_W-1:0] dq_out,
    input logic            dq_oe
);

    localparam int LIM     = WLO_CYC + (DQ_W - 1) * SKEW_STEP + 2;
    localparam int SINCE_W = $clog2(LIM + 1);
    localparam logic [SINCE_W-1:0] LIM_V  = SINCE_W'(LIM);
    localparam logic [SINCE_W-1:0] HIT_V  = SINCE_W'(WLO_CYC + 1);
    localparam logic [SINCE_W-1:0] ONE_V  = SINCE_W'(1);

    logic [SINCE_W-1:0] since_q;

    // Edges since the last strobe accepted in leveling mode, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= LIM_V;
        end else if (lvl_en && strobe_rise) begin
            since_q <= ONE_V;
        end else if (since_q < LIM_V) begin
            since_q <= since_q + ONE_V;
        end
    end

    // R2: disabled outputs are not driven and read zero.
    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_off |-> (!dq_oe && dq_out == '0));

    // R8: entering leveling shows cleared feedback.
    assert_entry_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_en) |-> (dq_out == '0));

    // R5: non-prime bits stay low in single-bit mode.
    assert_prime_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prime_only && $past(prime_only)) |-> (dq_out[DQ_W-1:1] == '0));

    // R9: all bits agree once the skew window is over.
    assert_uniform_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_en && $past(lvl_en) && !out_off && !prime_only && $past(!prime_only)
         && since_q == LIM_V)
        |-> ($countones(dq_out) == 0 || $countones(dq_out) == DQ_W));

    // R4: bit 0 only moves at its latency after an accepted strobe.
    assert_lane0_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dq_out[0]) && lvl_en && $past(lvl_en) && !out_off && $past(!out_off))
        |-> (since_q == HIT_V || since_q == ONE_V));

endmodule

bind wl_fb_responder wl_fb_responder_chk #(
    .DQ_W     (DQ_W),
    .WLO_CYC  (WLO_CYC),
    .SKEW_STEP(SKEW_STEP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_en     (lvl_en),
    .out_off    (out_off),
    .prime_only (prime_only),
    .strobe_rise(strobe_rise),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe)
);

// File: tb/wl_fb_responder_tb.sv
// Bench wl_fb_responder_tb
// Scoreboard bench. A driver task plays strobe bursts and queues the
// expected output word for each cycle of the burst. A monitor pops
// each word at the falling edge of its due cycle and compares it.
module wl_fb_responder_tb;

    localparam int  CLK_PERIOD = 10;
    localparam int  DQ_W       = 8;
    localparam int  WLO        = 4;
    localparam int  STEP       = 1;
    localparam int  MAXD       = WLO + (DQ_W - 1) * STEP;
    localparam int  WD_CYCLES  = 20000;

    typedef struct {
        int              due;
        logic [DQ_W-1:0] dq;
        logic            oe;
        string           tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            lvl_en;
    logic            out_off;
    logic            prime_only;
    logic            ck_level;
    logic            strobe_rise;
    logic [DQ_W-1:0] dq_out;
    logic            dq_oe;

    int              cyc = 0;
    int              n_checks = 0;
    int              n_fails = 0;
    bit              done = 1'b0;
    exp_t            sbq[$];
    exp_t            cur;
    logic [DQ_W-1:0] model_vec;
    int              b_ofs[4];
    bit              b_lev[4];

    wl_fb_responder #(
        .DQ_W     (DQ_W),
        .WLO_CYC  (WLO),
        .SKEW_STEP(STEP)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_en     (lvl_en),
        .out_off    (out_off),
        .prime_only (prime_only),
        .ck_level   (ck_level),
        .strobe_rise(strobe_rise),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int bit_lat(input int i);
        return WLO + i * STEP;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp_v, cyc);
        end
    endtask

    // Monitor: compare each queued word at the falling edge of its due cycle.
    always @(negedge clk) begin
        while (sbq.size() != 0 && sbq[0].due <= cyc) begin
            cur = sbq.pop_front();
            check(cur.tag, {23'd0, dq_oe, dq_out}, {23'd0, cur.oe, cur.dq});
        end
    end

    // Driver: queue expected words for a strobe burst, then play it.
    // It is called at a falling edge, and the first strobe is at offset 0.
    task automatic run_burst(input int n, input string tag);
        int base;
        int last;
        logic [DQ_W-1:0] v;
        base = cyc + 1;
        last = b_ofs[n-1];
        v = model_vec;
        for (int k = 0; k <= last + MAXD + 1; k++) begin
            exp_t e;
            for (int i = 0; i < DQ_W; i++) begin
                logic bv;
                bv = model_vec[i];
                if (prime_only && i != 0) begin
                    bv = 1'b0;
                end else begin
                    for (int s = 0; s < n; s++) begin
                        bit kept;
                        kept = 1'b1;
                        for (int t = s + 1; t < n; t++) begin
                            if (b_ofs[t] < b_ofs[s] + bit_lat(i)) kept = 1'b0;
                        end
                        if (kept && b_ofs[s] + bit_lat(i) <= k) bv = b_lev[s];
                    end
                end
                v[i] = bv;
            end
            e.due = base + k;
            e.oe  = lvl_en && !out_off;
            e.dq  = e.oe ? v : '0;
            e.tag = tag;
            sbq.push_back(e);
        end
        for (int k = 0; k <= last; k++) begin
            strobe_rise = 1'b0;
            for (int s = 0; s < n; s++) begin
                if (b_ofs[s] == k) begin
                    strobe_rise = 1'b1;
                    ck_level    = b_lev[s];
                end
            end
            @(negedge clk);
        end
        strobe_rise = 1'b0;
        while (sbq.size() != 0) @(negedge clk);
        model_vec = v;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        rst_n = 1'b0; lvl_en = 1'b0; out_off = 1'b0; prime_only = 1'b0;
        ck_level = 1'b0; strobe_rise = 1'b0; model_vec = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset oe", {31'd0, dq_oe}, 32'd0);
        check("R1 reset dq", {24'd0, dq_out}, 32'd0);

        // R3: strobe while leveling is off is ignored.
        ck_level = 1'b1; strobe_rise = 1'b1;
        @(negedge clk);
        strobe_rise = 1'b0;
        lvl_en = 1'b1;
        @(negedge clk);
        check("R2 oe on in leveling", {31'd0, dq_oe}, 32'd1);
        repeat (MAXD + 2) @(negedge clk);
        check("R3 ignored strobe", {24'd0, dq_out}, 32'd0);

        // R4 and R9: single strobes in all-bit mode.
        b_ofs[0] = 0; b_lev[0] = 1'b1;
        run_burst(1, "R4 rising staggered");
        check("R9 all equal high", {24'd0, dq_out}, 32'hFF);
        b_lev[0] = 1'b0;
        run_burst(1, "R4 falling staggered");
        check("R9 all equal low", {24'd0, dq_out}, 32'h00);
        b_lev[0] = 1'b1;
        run_burst(1, "R4 rising again");

        // R6: overlapping strobes replace pending updates.
        b_ofs[0] = 0; b_lev[0] = 1'b0;
        b_ofs[1] = 2; b_lev[1] = 1'b1;
        b_ofs[2] = 6; b_lev[2] = 1'b0;
        run_burst(3, "R6 overlap");
        check("R6 final word", {24'd0, dq_out}, 32'h00);

        // R7: disabled outputs while capture keeps running.
        out_off = 1'b1;
        @(negedge clk);
        check("R2 oe off when disabled", {31'd0, dq_oe}, 32'd0);
        b_ofs[0] = 0; b_lev[0] = 1'b1;
        run_burst(1, "R7 silent while disabled");
        out_off = 1'b0;
        #1;
        check("R7 feedback after release", {24'd0, dq_out}, 32'hFF);
        check("R7 oe after release", {31'd0, dq_oe}, 32'd1);

        // R8: leaving leveling clears the feedback.
        @(negedge clk);
        lvl_en = 1'b0;
        #1;
        check("R8 oe off on exit", {31'd0, dq_oe}, 32'd0);
        @(negedge clk);
        model_vec = '0;
        lvl_en = 1'b1;
        #1;
        check("R8 cleared on re-entry", {24'd0, dq_out}, 32'h00);

        // R5: single-bit mode, including a strobe on the due edge (R6).
        @(negedge clk);
        lvl_en = 1'b0;
        prime_only = 1'b1;
        @(negedge clk);
        lvl_en = 1'b1;
        @(negedge clk);
        b_ofs[0] = 0; b_lev[0] = 1'b1;
        run_burst(1, "R5 prime high");
        check("R5 prime word", {24'd0, dq_out}, 32'h01);
        b_ofs[0] = 0;   b_lev[0] = 1'b0;
        b_ofs[1] = WLO; b_lev[1] = 1'b1;
        run_burst(2, "R6 R5 strobe on due edge");
        check("R5 prime final", {24'd0, dq_out}, 32'h01);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule